// File: doc/BRIEF.md
# Mailbox Transmit Priority Arbiter

This block decides which of a bank of message mailboxes goes out next on a CAN-style bus. Each mailbox has three things: an enable bit, a direction bit, and a 16-bit control word. The control word holds a transmit priority, a remote-request flag and a data length code. Software marks mailboxes for sending by writing a bit mask into the transmit-request register. Among the mailboxes that are pending, enabled and set to transmit, the arbiter picks the one with the largest priority value. If several share that value, the highest-numbered one wins. The arbiter then hands the winner's index, length code and remote flag to a frame serializer and holds them until the serializer reports completion.

On completion, the sent mailbox leaves the pending set and its acknowledge bit sets. Software clears acknowledge bits by writing ones. A global mailbox interrupt flag stays high while any acknowledged mailbox has its interrupt-mask bit set.

Top module: `mbox_tx_arbiter`

## Requirements
- R1: After reset the pending vector, the acknowledge vector, the interrupt flag and `tx_req` are all zero.
- R2: A mailbox is only launched if it is pending, its enable bit is 1 and its direction bit is 0 (1 means receive). A pending mailbox that fails either of the last two conditions stays pending and is not sent. When it becomes eligible it is sent.
- R3: Among eligible mailboxes, the winner has the largest priority. The priority is the 6-bit field in control-word bits [13:8].
- R4: If several eligible mailboxes share the largest priority, the highest-numbered of them wins.
- R5: A request write sampled at clock edge k sets the pending bits selected by ones in the mask at edge k. Zero mask bits leave pending bits unchanged. If the mailbox wins, `tx_req` is high from edge k+1.
- R6: While a frame is in flight, `tx_req`, `tx_index`, `tx_dlc` and `tx_rtr` hold, and requests arriving in the meantime do not change the selection. After `tx_done` is sampled, `tx_req` is low for one cycle, and then the next winner is launched.
- R7: At the edge that samples `tx_req` and `tx_done` both high, the sent mailbox's pending bit clears and its acknowledge bit sets.
- R8: An acknowledge-clear write clears the acknowledge bits selected by ones and leaves the others unchanged. A set and a clear of the same bit at the same edge leave the bit set.
- R9: `gmif` is high exactly when some acknowledge bit is set whose interrupt-mask bit was 1 at the edge that last updated it.
- R10: `tx_dlc` (control-word bits [3:0]) and `tx_rtr` (bit 4) are captured from the winner's control word at launch. Later changes to that word do not alter them.
- R11: With no eligible mailbox and no frame in flight, `tx_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mb_enable | input | 32 | Per-mailbox enable |
| mb_dir | input | 32 | Per-mailbox direction, 0 transmit, 1 receive |
| mb_ctrl | input | 512 | Control words, mailbox i at bits [16i+15:16i] |
| req_wr | input | 1 | Transmit-request write strobe |
| req_mask | input | 32 | Mailboxes to mark pending |
| ack_clr_wr | input | 1 | Acknowledge-clear write strobe |
| ack_clr_mask | input | 32 | Acknowledge bits to clear |
| irq_mask | input | 32 | Per-mailbox interrupt mask |
| tx_done | input | 1 | Serializer finished the current frame |
| tx_req | output | 1 | Frame in flight, index valid |
| tx_index | output | 5 | Mailbox being sent |
| tx_dlc | output | 4 | Length code captured at launch |
| tx_rtr | output | 1 | Remote flag captured at launch |
| pending | output | 32 | Pending transmit requests |
| ack | output | 32 | Transmit acknowledge bits |
| gmif | output | 1 | Global mailbox interrupt flag |

## Verification
The hardest situation to create is a new, stronger request that arrives while a weaker frame is already in flight. If it reaches the arbiter at the wrong moment, it can hide a design that re-arbitrates mid-frame. The bench launches a low-priority mailbox, then raises a priority-63 request two cycles into the frame and edits the in-flight control word. It checks that index and length code hold until completion and that the new request wins only in the following round. A second hard case is a set and a clear landing on the same acknowledge bit at one edge. The bench reaches it by pulsing the clear strobe on the completion cycle.

// File: rtl/mbox_arb_pkg.sv
package mbox_arb_pkg;
    localparam int CTRL_W   = 16;
    localparam int PRIO_LSB = 8;
    localparam int PRIO_W   = 6;
    localparam int RTR_POS  = 4;
    localparam int DLC_W    = 4;
endpackage

// File: rtl/mbox_prio_select.sv
module mbox_prio_select #(
    parameter int N_MBOX = 32,
    parameter int PRIO_W = 6
) (
    input  logic [N_MBOX-1:0]        elig,
    input  logic [N_MBOX*PRIO_W-1:0] prio_flat,
    output logic                     win_valid,
    output logic [$clog2(N_MBOX)-1:0] win_idx
);
    localparam int IDX_W = $clog2(N_MBOX);
    localparam int KEY_W = 1 + PRIO_W + IDX_W;

    // key = {eligible, priority, index}: the largest key is the winner
    logic [KEY_W-1:0] leaf [N_MBOX];
    logic [KEY_W-1:0] tree [1:2*N_MBOX-1];

    for (genvar g = 0; g < N_MBOX; g++) begin : g_leaf
        assign leaf[g] = {elig[g], prio_flat[g*PRIO_W +: PRIO_W], IDX_W'(g)};
    end

    always_comb begin
        for (int i = 0; i < N_MBOX; i++) begin
            tree[N_MBOX + i] = leaf[i];
        end
        for (int i = N_MBOX - 1; i >= 1; i--) begin
            tree[i] = (tree[2*i] > tree[2*i+1]) ? tree[2*i] : tree[2*i+1];
        end
    end

    assign win_valid = tree[1][KEY_W-1];
    assign win_idx   = tree[1][IDX_W-1:0];
endmodule

// File: rtl/mbox_ack_irq.sv
module mbox_ack_irq #(
    parameter int N_MBOX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MBOX-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [N_MBOX-1:0] clr_mask,
    input  logic [N_MBOX-1:0] irq_mask,
    output logic [N_MBOX-1:0] ack_q,
    output logic              gmif_q
);
    typedef struct packed {
        logic [N_MBOX-1:0] ack;
        logic              gmif;
    } ack_state_t;

    ack_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr) begin
            st_d.ack = st_q.ack & ~clr_mask;
        end
        st_d.ack  = st_d.ack | set_vec;          // a set beats a clear
        st_d.gmif = |(st_d.ack & irq_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_q  = st_q.ack;
    assign gmif_q = st_q.gmif;

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((ack_q & $past(clr_mask & ~set_vec)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((ack_q & $past(set_vec)) == $past(set_vec)));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmif_q) |-> (|(ack_q & $past(irq_mask))));
endmodule

// File: rtl/mbox_tx_arbiter.sv
module mbox_tx_arbiter
    import mbox_arb_pkg::*;
#(
    parameter int N_MBOX = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MBOX-1:0]        mb_enable,
    input  logic [N_MBOX-1:0]        mb_dir,
    input  logic [N_MBOX*CTRL_W-1:0] mb_ctrl,
    input  logic                     req_wr,
    input  logic [N_MBOX-1:0]        req_mask,
    input  logic                     ack_clr_wr,
    input  logic [N_MBOX-1:0]        ack_clr_mask,
    input  logic [N_MBOX-1:0]        irq_mask,
    input  logic                     tx_done,
    output logic                     tx_req,
    output logic [$clog2(N_MBOX)-1:0] tx_index,
    output logic [DLC_W-1:0]         tx_dlc,
    output logic                     tx_rtr,
    output logic [N_MBOX-1:0]        pending,
    output logic [N_MBOX-1:0]        ack,
    output logic                     gmif
);
    localparam int IDX_W = $clog2(N_MBOX);

    typedef struct packed {
        logic [N_MBOX-1:0] pend;
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [DLC_W-1:0]  dlc;
        logic              rtr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [CTRL_W-1:0]        ctrl_arr [N_MBOX];
    logic [PRIO_W-1:0]        prio_arr [N_MBOX];
    logic [N_MBOX*PRIO_W-1:0] prio_flat;
    logic [N_MBOX-1:0]        elig;
    logic [N_MBOX-1:0]        done_vec;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    logic                     launch;

    for (genvar g = 0; g < N_MBOX; g++) begin : g_field
        assign ctrl_arr[g] = mb_ctrl[g*CTRL_W +: CTRL_W];
        assign prio_arr[g] = ctrl_arr[g][PRIO_LSB +: PRIO_W];
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_arr[g];
    end

    assign elig = st_q.pend & mb_enable & ~mb_dir;

    mbox_prio_select #(
        .N_MBOX (N_MBOX),
        .PRIO_W (PRIO_W)
    ) u_select (
        .elig      (elig),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    assign launch   = !st_q.busy && win_valid;
    assign done_vec = (st_q.busy && tx_done) ? (N_MBOX'(1) << st_q.idx) : '0;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~done_vec) | (req_wr ? req_mask : '0);
        if (st_q.busy) begin
            if (tx_done) begin
                st_d.busy = 1'b0;
            end
        end else if (win_valid) begin
            st_d.busy = 1'b1;
            st_d.idx  = win_idx;
            st_d.dlc  = ctrl_arr[win_idx][DLC_W-1:0];
            st_d.rtr  = ctrl_arr[win_idx][RTR_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    mbox_ack_irq #(
        .N_MBOX (N_MBOX)
    ) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (done_vec),
        .clr_wr   (ack_clr_wr),
        .clr_mask (ack_clr_mask),
        .irq_mask (irq_mask),
        .ack_q    (ack),
        .gmif_q   (gmif)
    );

    assign tx_req   = st_q.busy;
    assign tx_index = st_q.idx;
    assign tx_dlc   = st_q.dlc;
    assign tx_rtr   = st_q.rtr;
    assign pending  = st_q.pend;

    assert_launch_elig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> elig[win_idx]);

    always_ff @(posedge clk) begin
        if (rst_n && launch) begin
            for (int i = 0; i < N_MBOX; i++) begin
                if (elig[i]) begin
                    assert_prio_win_R3: assert (prio_arr[i] <= prio_arr[win_idx]);
                    assert_tie_win_R4: assert (!(prio_arr[i] == prio_arr[win_idx]
                                                 && IDX_W'(i) > win_idx));
                end
            end
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_index) && $stable(tx_dlc)));

    assert_done_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done) |=> (!tx_req && ((ack & $past(done_vec)) == $past(done_vec))));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_req && elig == '0) |=> !tx_req);
endmodule

// File: tb/tb_mbox_tx_arbiter.sv
module tb_mbox_tx_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  mb_enable = '0;
    logic [N-1:0]  mb_dir = '0;
    logic [N*16-1:0] mb_ctrl = '0;
    logic          req_wr = 1'b0;
    logic [N-1:0]  req_mask = '0;
    logic          ack_clr_wr = 1'b0;
    logic [N-1:0]  ack_clr_mask = '0;
    logic [N-1:0]  irq_mask = '0;
    logic          tx_done = 1'b0;
    logic          tx_req;
    logic [4:0]    tx_index;
    logic [3:0]    tx_dlc;
    logic          tx_rtr;
    logic [N-1:0]  pending;
    logic [N-1:0]  ack;
    logic          gmif;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_tx_arbiter #(.N_MBOX(N)) dut (
        .clk(clk), .rst_n(rst_n), .mb_enable(mb_enable), .mb_dir(mb_dir),
        .mb_ctrl(mb_ctrl), .req_wr(req_wr), .req_mask(req_mask),
        .ack_clr_wr(ack_clr_wr), .ack_clr_mask(ack_clr_mask), .irq_mask(irq_mask),
        .tx_done(tx_done), .tx_req(tx_req), .tx_index(tx_index), .tx_dlc(tx_dlc),
        .tx_rtr(tx_rtr), .pending(pending), .ack(ack), .gmif(gmif)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mb(int idx, logic en, logic dir, logic [5:0] prio,
                          logic rtr, logic [3:0] dlc);
        mb_enable[idx] = en;
        mb_dir[idx]    = dir;
        mb_ctrl[idx*16 +: 16] = {2'b00, prio, 3'b000, rtr, dlc};
    endtask

    task automatic request(logic [N-1:0] m);
        req_wr = 1'b1; req_mask = m;
        tick();
        req_wr = 1'b0; req_mask = '0;
    endtask

    task automatic clear_ack(logic [N-1:0] m);
        ack_clr_wr = 1'b1; ack_clr_mask = m;
        tick();
        ack_clr_wr = 1'b0; ack_clr_mask = '0;
    endtask

    // expects a frame in flight; checks its index, completes it, then steps once
    task automatic serve(int exp_idx, string req);
        chk(req, {31'd0, tx_req}, 32'd1);
        chk(req, {27'd0, tx_index}, exp_idx);
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        chk("R7", {31'd0, ack[exp_idx]}, 32'd1);
        chk("R7", {31'd0, pending[exp_idx]}, 32'd0);
        chk("R6", {31'd0, tx_req}, 32'd0);
        tick();
    endtask

    task automatic test_reset();
        chk("R1", pending, 32'd0);
        chk("R1", ack, 32'd0);
        chk("R1", {31'd0, gmif}, 32'd0);
        chk("R1", {31'd0, tx_req}, 32'd0);
    endtask

    task automatic test_priority();
        set_mb(3, 1, 0, 6'd10, 0, 4'd1);
        set_mb(20, 1, 0, 6'd40, 0, 4'd2);
        set_mb(7, 1, 0, 6'd63, 0, 4'd3);
        request((32'd1 << 3) | (32'd1 << 20) | (32'd1 << 7));
        tick();
        serve(7, "R3");
        serve(20, "R3");
        serve(3, "R3");
        chk("R11", {31'd0, tx_req}, 32'd0);
        clear_ack('1);
    endtask

    task automatic test_tie();
        set_mb(5, 1, 0, 6'd12, 0, 4'd0);
        set_mb(9, 1, 0, 6'd12, 0, 4'd0);
        set_mb(30, 1, 0, 6'd12, 0, 4'd0);
        set_mb(0, 1, 0, 6'd11, 0, 4'd0);
        request((32'd1 << 5) | (32'd1 << 9) | (32'd1 << 30) | 32'd1);
        tick();
        serve(30, "R4");
        serve(9, "R4");
        serve(5, "R4");
        serve(0, "R4");
        clear_ack('1);
    endtask

    task automatic test_eligibility();
        set_mb(12, 1, 1, 6'd63, 0, 4'd0);   // receive direction
        set_mb(13, 0, 0, 6'd63, 0, 4'd0);   // disabled
        set_mb(2, 1, 0, 6'd1, 0, 4'd0);
        request((32'd1 << 12) | (32'd1 << 13) | (32'd1 << 2));
        tick();
        serve(2, "R2");
        tick();
        chk("R2", {31'd0, tx_req}, 32'd0);
        chk("R2", pending, (32'd1 << 12) | (32'd1 << 13));
        mb_enable[13] = 1'b1;
        tick();
        serve(13, "R2");
        mb_dir[12] = 1'b0;
        tick();
        serve(12, "R2");
        clear_ack('1);
    endtask

    task automatic test_zero_mask();
        set_mb(10, 0, 0, 6'd0, 0, 4'd0);
        set_mb(11, 0, 0, 6'd0, 0, 4'd0);
        request(32'd1 << 10);
        request(32'd1 << 11);
        chk("R5", pending, (32'd1 << 10) | (32'd1 << 11));
        request('0);
        chk("R5", pending, (32'd1 << 10) | (32'd1 << 11));
        mb_enable[10] = 1'b1;
        mb_enable[11] = 1'b1;
        tick();
        serve(11, "R5");
        serve(10, "R5");
        clear_ack('1);
    endtask

    task automatic test_inflight();
        set_mb(1, 1, 0, 6'd5, 0, 4'd3);
        set_mb(31, 1, 0, 6'd63, 1, 4'd7);
        req_wr = 1'b1; req_mask = 32'd1 << 1;
        tick();
        req_wr = 1'b0; req_mask = '0;
        chk("R5", {31'd0, tx_req}, 32'd0);
        tick();
        chk("R5", {31'd0, tx_req}, 32'd1);
        chk("R10", {28'd0, tx_dlc}, 32'd3);
        request(32'd1 << 31);
        tick();
        chk("R6", {27'd0, tx_index}, 32'd1);
        set_mb(1, 1, 0, 6'd5, 1, 4'd8);
        tick();
        chk("R10", {28'd0, tx_dlc}, 32'd3);
        chk("R10", {31'd0, tx_rtr}, 32'd0);
        serve(1, "R6");
        chk("R10", {28'd0, tx_dlc}, 32'd7);
        chk("R10", {31'd0, tx_rtr}, 32'd1);
        serve(31, "R6");
        clear_ack('1);
    endtask

    task automatic test_ack_irq();
        irq_mask = 32'd1 << 6;
        set_mb(4, 1, 0, 6'd20, 0, 4'd0);
        request(32'd1 << 4);
        tick();
        serve(4, "R9");
        chk("R9", {31'd0, gmif}, 32'd0);
        set_mb(6, 1, 0, 6'd20, 0, 4'd0);
        request(32'd1 << 6);
        tick();
        // completion and clear of the same bit on one edge
        tx_done = 1'b1; ack_clr_wr = 1'b1; ack_clr_mask = 32'd1 << 6;
        tick();
        tx_done = 1'b0; ack_clr_wr = 1'b0; ack_clr_mask = '0;
        chk("R8", {31'd0, ack[6]}, 32'd1);
        chk("R9", {31'd0, gmif}, 32'd1);
        clear_ack(32'd1 << 6);
        chk("R8", ack, 32'd1 << 4);
        chk("R9", {31'd0, gmif}, 32'd0);
        clear_ack(32'd1 << 4);
        chk("R8", ack, 32'd0);
        irq_mask = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_priority();
        test_tie();
        test_eligibility();
        test_zero_mask();
        test_inflight();
        test_ack_irq();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule